// File: doc/BRIEF.md
# Vsync-Paced Alpha Fade Controller

This block generates an 8-bit blending alpha that ramps up or down over successive video frames, for fade-in and fade-out effects. Software programs a 32-bit staging word that holds a start alpha, a step size, a frame divider, a direction and an enable. The staged values stay invisible to the video path until software sets a self-clearing commit bit. The transfer into the active set then happens on the next vertical sync pulse.

After a commit the running alpha reloads from the start value. Once every N vsync periods it moves by the step size toward 0x00 or 0xFF. When it reaches that limit, the fade ends and a read-only busy bit drops. Vsync is a one-cycle pulse that is synchronous to the block clock. The block contains no pixel arithmetic and no timing generation.

Top module: `alpha_fade_ctrl`

## Requirements
- R1: After reset, the read word is 0xFF000000, `alpha_out` is 0xFF and `fade_busy` is 0.
- R2: The read word carries the staged start alpha in [31:24], the step in [23:16], the divider in [15:8], the pending commit in [7], busy in [4], direction in [1] and enable in [0]. Bits [6:5], [3] and [2] always read 0. Writes to [4] and to the reserved bits have no effect.
- R3: Staged values do not affect `alpha_out` until a vsync pulse arrives with a commit pending. That pulse loads `alpha_out` with the staged start alpha and restarts the frame count.
- R4: Writing 1 to bit [7] arms a commit, and the vsync that performs the commit clears the bit. A write in the same cycle as that vsync does not change what is committed: the values committed are the ones staged before that write. The write's own bit [7] decides whether a new commit is pending afterwards.
- R5: While a fade runs, the alpha moves by the step size once every `divider` vsync pulses. A divider of 0 behaves like 1.
- R6: Direction 1 adds the step and saturates at 0xFF. Direction 0 subtracts the step and saturates at 0x00. Reaching the limit clears `fade_busy`, and the alpha then holds.
- R7: With enable 0, the committed start alpha holds on `alpha_out` and `fade_busy` stays 0 across vsync pulses.
- R8: A commit whose step is 0, or whose start alpha already equals the limit for its direction, leaves `fade_busy` at 0.
- R9: `alpha_out` changes only in the cycle after a vsync pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | One-cycle vertical sync pulse |
| reg_wr | input | 1 | Write strobe for the staging word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Staging word readback with live busy |
| alpha_out | output | 8 | Current blending alpha |
| fade_busy | output | 1 | A fade is in progress |

## Verification
Two actions can land in one cycle: a register write and the vsync pulse that commits an earlier armed write. The bench first arms one configuration. It then writes a second, re-armed configuration with the strobe in the same cycle as vsync. The check passes only if the first configuration's start alpha appears on the output and the commit bit still reads 1. A further vsync must then load the second configuration and clear the bit.

// File: rtl/alpha_fade_pkg.sv
package alpha_fade_pkg;
   localparam int FIELD_W  = 8;
   localparam int WORD_W   = 32;
   localparam int POS_START = 24;
   localparam int POS_COEF  = 16;
   localparam int POS_RATE  = 8;
   localparam int POS_ARM   = 7;
   localparam int POS_BUSY  = 4;
   localparam int POS_DIR   = 1;
   localparam int POS_EN    = 0;

   typedef struct packed {
      logic [FIELD_W-1:0] start;
      logic [FIELD_W-1:0] coef;
      logic [FIELD_W-1:0] rate;
      logic               dir;
      logic               en;
   } fade_cfg_t;
endpackage

// File: rtl/afc_regfile.sv
module afc_regfile
   import alpha_fade_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              vsync,
   input  logic              busy,
   output fade_cfg_t         stage,
   output logic              pend,
   output logic [WORD_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage.start <= '1;
         stage.coef  <= '0;
         stage.rate  <= '0;
         stage.dir   <= 1'b0;
         stage.en    <= 1'b0;
         pend        <= 1'b0;
      end else if (wr) begin
         stage.start <= wdata[POS_START +: FIELD_W];
         stage.coef  <= wdata[POS_COEF  +: FIELD_W];
         stage.rate  <= wdata[POS_RATE  +: FIELD_W];
         stage.dir   <= wdata[POS_DIR];
         stage.en    <= wdata[POS_EN];
         pend        <= wdata[POS_ARM];
      end else if (vsync) begin
         pend <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      rdata[POS_START +: FIELD_W] = stage.start;
      rdata[POS_COEF  +: FIELD_W] = stage.coef;
      rdata[POS_RATE  +: FIELD_W] = stage.rate;
      rdata[POS_ARM]  = pend;
      rdata[POS_BUSY] = busy;
      rdata[POS_DIR]  = stage.dir;
      rdata[POS_EN]   = stage.en;
   end

   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && vsync && !wr) |=> !pend); // R4
   AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (pend == $past(wdata[POS_ARM]))); // R4
endmodule

// File: rtl/afc_rate_div.sv
module afc_rate_div #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate_in,
   input  logic              adv,
   output logic              step
);
   logic [RATE_W-1:0] rate_q, cnt_q, last;

   assign last = (rate_q == '0) ? '0 : rate_q - 1'b1;
   assign step = adv && (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         cnt_q  <= '0;
      end else if (restart) begin
         rate_q <= rate_in;
         cnt_q  <= '0;
      end else if (adv) begin
         cnt_q <= step ? '0 : cnt_q + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q > 1) |-> (cnt_q < rate_q)); // R5
   AST_ZERO_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && rate_q == '0) |-> step); // R5
endmodule

// File: rtl/afc_stepper.sv
module afc_stepper
   import alpha_fade_pkg::*;
#(
   parameter int ALPHA_W   = 8,
   parameter int STEP_IMPL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  fade_cfg_t          stage,
   input  logic               step,
   input  logic               vsync,
   output logic [ALPHA_W-1:0] alpha,
   output logic               busy
);
   localparam logic [ALPHA_W-1:0] A_MAX = '1;
   localparam logic [ALPHA_W-1:0] A_MIN = '0;

   logic [ALPHA_W-1:0] coef_q, nxt;
   logic               dir_q, en_q, hit, start_at_lim;

   generate
      if (STEP_IMPL == 0) begin : g_shared
         logic [ALPHA_W-1:0] opnd;
         logic [ALPHA_W:0]   sum;
         assign opnd = dir_q ? coef_q : ~coef_q;
         assign sum  = {1'b0, alpha} + {1'b0, opnd} + {{ALPHA_W{1'b0}}, ~dir_q};
         always_comb begin
            if (dir_q) hit = sum[ALPHA_W] || (sum[ALPHA_W-1:0] == A_MAX);
            else       hit = !sum[ALPHA_W] || (sum[ALPHA_W-1:0] == A_MIN);
            nxt = hit ? (dir_q ? A_MAX : A_MIN) : sum[ALPHA_W-1:0];
         end
      end else begin : g_split
         logic [ALPHA_W:0] up_sum;
         logic             dn_sat;
         assign up_sum = {1'b0, alpha} + {1'b0, coef_q};
         assign dn_sat = (alpha <= coef_q);
         always_comb begin
            if (dir_q) begin
               hit = up_sum[ALPHA_W] || (up_sum[ALPHA_W-1:0] == A_MAX);
               nxt = hit ? A_MAX : up_sum[ALPHA_W-1:0];
            end else begin
               hit = dn_sat;
               nxt = dn_sat ? A_MIN : alpha - coef_q;
            end
         end
      end
   endgenerate

   assign start_at_lim = stage.dir ? (stage.start == A_MAX) : (stage.start == A_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alpha  <= A_MAX;
         busy   <= 1'b0;
         coef_q <= '0;
         dir_q  <= 1'b0;
         en_q   <= 1'b0;
      end else if (commit) begin
         alpha  <= stage.start;
         coef_q <= stage.coef;
         dir_q  <= stage.dir;
         en_q   <= stage.en;
         busy   <= stage.en && (stage.coef != '0) && !start_at_lim;
      end else if (step && busy) begin
         alpha <= nxt;
         if (hit) busy <= 1'b0;
      end
   end

   AST_ALPHA_AFTER_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> $stable(alpha)); // R9
   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !busy); // R7
   AST_BUSY_OFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (alpha != (dir_q ? A_MAX : A_MIN))); // R6
   AST_DOWN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !dir_q) |=> (alpha <= $past(alpha))); // R6
   AST_UP_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && dir_q) |=> (alpha >= $past(alpha))); // R6
   AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (alpha == $past(stage.start))); // R3
endmodule

// File: rtl/alpha_fade_ctrl.sv
module alpha_fade_ctrl
   import alpha_fade_pkg::*;
#(
   parameter int ALPHA_W   = 8,
   parameter int RATE_W    = 8,
   parameter int STEP_IMPL = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        vsync,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic [7:0]  alpha_out,
   output logic        fade_busy
);
   if (ALPHA_W != FIELD_W) begin : g_bad_alpha
      $error("ALPHA_W must match the register field width");
   end
   if (RATE_W != FIELD_W) begin : g_bad_rate
      $error("RATE_W must match the register field width");
   end
   if (STEP_IMPL < 0 || STEP_IMPL > 1) begin : g_bad_impl
      $error("STEP_IMPL must be 0 or 1");
   end

   fade_cfg_t          stage;
   logic               pend, commit, step, busy;
   logic [ALPHA_W-1:0] alpha;

   assign commit = vsync && pend;

   afc_regfile u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .vsync (vsync),
      .busy  (busy),
      .stage (stage),
      .pend  (pend),
      .rdata (reg_rdata)
   );

   afc_rate_div #(.RATE_W(RATE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (commit),
      .rate_in (stage.rate),
      .adv     (vsync && busy && !commit),
      .step    (step)
   );

   afc_stepper #(.ALPHA_W(ALPHA_W), .STEP_IMPL(STEP_IMPL)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .stage  (stage),
      .step   (step),
      .vsync  (vsync),
      .alpha  (alpha),
      .busy   (busy)
   );

   assign alpha_out = alpha;
   assign fade_busy = busy;
endmodule

// File: tb/alpha_fade_ctrl_test.sv
module alpha_fade_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vsync = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  alpha_out;
   logic        fade_busy;
   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   alpha_fade_ctrl uut (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .alpha_out(alpha_out), .fade_busy(fade_busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [31:0] w);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input int gap);
      @(negedge clk);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      for (int k = 0; k < gap; k++) @(negedge clk);
   endtask

   function automatic logic [31:0] cfg(input logic [7:0] s, input logic [7:0] c,
                                       input logic [7:0] r, input bit d, input bit e, input bit arm);
      return {s, c, r, arm, 5'b0, d, e};
   endfunction

   initial begin
      int m_a, m_cnt, eff, extra;
      bit m_busy;
      logic [7:0] starts[5] = '{8'h00, 8'h10, 8'h80, 8'hF0, 8'hFF};
      logic [7:0] coefs[4]  = '{8'h00, 8'h03, 8'h37, 8'hFF};
      logic [7:0] rates[3]  = '{8'h00, 8'h01, 8'h03};

      repeat (3) @(negedge clk);
      check("R1 rdata", reg_rdata, 32'hFF00_0000);
      check("R1 alpha", {24'b0, alpha_out}, 32'hFF);
      check("R1 busy", {31'b0, fade_busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: disabled commit holds start, idle
      write_word(cfg(8'h42, 8'h10, 8'h01, 1'b0, 1'b0, 1'b1));
      check("R4 armed reads 1", {31'b0, reg_rdata[7]}, 1);
      check("R3 not applied before vsync", {24'b0, alpha_out}, 32'hFF);
      pulse(1);
      check("R4 cleared after commit", {31'b0, reg_rdata[7]}, 0);
      check("R3 start loaded", {24'b0, alpha_out}, 32'h42);
      pulse(1); pulse(1);
      check("R7 alpha holds when off", {24'b0, alpha_out}, 32'h42);
      check("R7 busy stays 0", {31'b0, fade_busy}, 0);

      // R2: readback layout, reserved and busy bits not writable
      write_word(32'hFFFF_FFFF);
      check("R2 readback reserved zero", reg_rdata, 32'hFFFF_FF83);
      pulse(1);
      check("R2 busy not writable / R8 start at limit", {31'b0, fade_busy}, 0);

      // R3: vsync without pending commit does not reload
      write_word(cfg(8'h20, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0));
      pulse(1);
      check("R3 no reload without arm", {24'b0, alpha_out}, 32'hFF);

      // R4: write collides with committing vsync
      write_word(cfg(8'h20, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1));
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = cfg(8'h90, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1); vsync = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; vsync = 1'b0;
      check("R4 collision commits old value", {24'b0, alpha_out}, 32'h20);
      check("R4 collision leaves new arm", {31'b0, reg_rdata[7]}, 1);
      pulse(1);
      check("R4 next vsync commits new", {24'b0, alpha_out}, 32'h90);
      check("R4 cleared after second commit", {31'b0, reg_rdata[7]}, 0);

      // R9: alpha stable between vsyncs while running
      write_word(cfg(8'h80, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1));
      pulse(0);
      pulse(0);
      repeat (5) @(negedge clk);
      check("R9 stable between vsync", {24'b0, alpha_out}, 32'h81);

      // R3: recommit mid-fade restarts from new start and counter
      write_word(cfg(8'h50, 8'h10, 8'h02, 1'b0, 1'b1, 1'b1));
      pulse(0);
      check("R3 mid-fade reload", {24'b0, alpha_out}, 32'h50);
      pulse(0);
      check("R5 first vsync no step at rate 2", {24'b0, alpha_out}, 32'h50);
      pulse(0);
      check("R5 second vsync steps", {24'b0, alpha_out}, 32'h40);

      // R5 R6 R8: sweep
      for (int d = 0; d < 2; d++)
         for (int si = 0; si < 5; si++)
            for (int ci = 0; ci < 4; ci++)
               for (int ri = 0; ri < 3; ri++) begin
                  write_word(cfg(starts[si], coefs[ci], rates[ri], d[0], 1'b1, 1'b1));
                  pulse(0);
                  m_a = starts[si];
                  m_cnt = 0;
                  eff = (rates[ri] == 0) ? 1 : rates[ri];
                  m_busy = (coefs[ci] != 0) && (d ? (m_a != 255) : (m_a != 0));
                  check("R8 commit alpha", {24'b0, alpha_out}, {24'b0, starts[si]});
                  check("R8 commit busy", {31'b0, fade_busy}, {31'b0, m_busy});
                  extra = 0;
                  while (m_busy || extra < 2) begin
                     if (!m_busy) extra++;
                     pulse(0);
                     if (m_busy) begin
                        m_cnt++;
                        if (m_cnt >= eff) begin
                           m_cnt = 0;
                           if (d == 1) m_a = m_a + coefs[ci];
                           else        m_a = m_a - coefs[ci];
                           if (m_a >= 255) begin m_a = 255; m_busy = (d != 1); end
                           if (m_a <= 0)   begin m_a = 0;   m_busy = (d != 0); end
                        end
                     end
                     check("R5 R6 alpha step", {24'b0, alpha_out}, m_a[31:0]);
                     check("R6 busy", {31'b0, reg_rdata[4]}, {31'b0, m_busy});
                  end
               end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule